// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block steps an external dual-slope integrating converter through its conversion cycle. A two-bit phase code selects auto-zero, signal integration, reference de-integration and integrator discharge in turn. All sequencing runs on a slow tick. The tick is one clock in every four.

Auto-zero and integration each last a programmable number of ticks. The count comes from a timing value that fills the upper bits of the phase counter. The lower byte of that counter always starts at zero and counts through to all-ones. De-integration is timed with the same counter until the comparator falls. The elapsed count, an overrange flag and a polarity flag are then published as a fresh result when the next auto-zero begins.

An active-low data-valid output marks auto-zero. Because of that it doubles as a result-ready indication. An active-low run input, or a load strobe on the parallel timing port, forces and holds auto-zero.

Top module: `dsadc_phase_seq`

## Requirements
- R1: The phase code on `phaseCode` ({A,B}) is 01 for auto-zero, 10 for integrate, 11 for de-integrate and 00 for integrator zero. Without forcing, the phases follow AZ, INT, DINT, IZ and back to AZ.
- R2: State changes happen only on a tick. A tick is every 4th clock (parameter `TICK_DIV`). The first tick is the 4th rising clock edge after reset is released.
- R3: AZ and INT each last 2^CNT_W − 256·L ticks, where L is the active timing value. With the defaults, L = 0xFF gives 256 ticks and L = 0x00 gives 65536 ticks.
- R4: DINT follows INT directly, with the counter cleared. The result count is the number of DINT ticks that come before the tick on which the synchronized comparator is first seen low after having been high.
- R5: IZ follows DINT directly. It lasts until a tick on which the synchronized comparator is high.
- R6: While `convEnN` is high at a tick, the phase becomes AZ and stays there. With `convEnN` low, conversions repeat without end.
- R7: `dataValidN` is 0 exactly while the phase code is AZ, whether AZ was entered normally or by forcing.
- R8: After reset the phase is IZ, `dataValidN` is 1 and the result outputs are 0. IZ is not left until at least one forced AZ has occurred, whatever the comparator level.
- R9: The result outputs change only on a normal IZ to AZ step. A forced AZ never changes them.
- R10: If the de-integrate counter reaches all-ones with no falling comparator edge, the phase moves to IZ and the next result has `resultOver` = 1 and `resultCount` all-ones.
- R11: `resultPol` is the synchronized comparator level at the final INT tick, where 1 means a positive input. The comparator passes through two clock flops before it is used.
- R12: `loadValue` is captured only while `loadStrobe` is high. The strobe must be held for at least one tick period, and it forces AZ just as `convEnN` does. A captured value takes effect only when an AZ count starts. A change on `loadValue` without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, divided internally to form the tick |
| rstN | input | 1 | Asynchronous active-low reset |
| convEnN | input | 1 | Active-low run enable; high forces and holds AZ |
| loadStrobe | input | 1 | Timing-value strobe; captures `loadValue` and forces AZ |
| loadValue | input | CNT_W-8 | Upper bits of the AZ/INT phase counter start value |
| cmptrIn | input | 1 | Asynchronous zero-crossing comparator from the converter |
| phaseCode | output | 2 | {A,B} phase code to the converter |
| dataValidN | output | 1 | Low while in AZ; low also means a new result is ready |
| resultCount | output | CNT_W | De-integrate count of the last completed conversion |
| resultOver | output | 1 | Overrange flag of the last completed conversion |
| resultPol | output | 1 | Polarity flag of the last completed conversion |

## Verification
A wrong phase or counter value shows on `phaseCode` no later than the next tick, four clocks on. A wrong counter start shows as an AZ or INT run that has the wrong length in clocks. A fault in comparator synchronization or de-integrate counting stays hidden until the following auto-zero starts, when `resultCount`, `resultOver` and `resultPol` take the wrong values. The bench compares every port against a behavioural model on every clock. It also measures phase lengths and result values against closed-form expressions.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_IZ   = 2'b00,
    PH_AZ   = 2'b01,
    PH_INT  = 2'b10,
    PH_DINT = 2'b11
  } phase_e;

  typedef struct packed {
    logic tick;
    logic ldAz;
    logic ldInt;
    logic clrCnt;
    logic incCnt;
    logic capDint;
    logic capOver;
    logic capPol;
    logic pubResult;
  } seqStrobe_t;

  // successor in the unforced cycle, used by checks
  function automatic phase_e nextPhase(phase_e p);
    case (p)
      PH_AZ:   return PH_INT;
      PH_INT:  return PH_DINT;
      PH_DINT: return PH_IZ;
      default: return PH_AZ;
    endcase
  endfunction

endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       forceAz,
  input  logic       cntMax,
  input  logic       cmpLvl,
  input  logic       cmpFall,
  output phase_e     phaseQ,
  output seqStrobe_t strb
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] divQ;
  logic             tick;
  logic             armedQ, armedD;
  phase_e           phaseD;

  assign tick = (divQ == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ   <= '0;
      phaseQ <= PH_IZ;
      armedQ <= 1'b0;
    end else begin
      divQ   <= tick ? '0 : divQ + 1'b1;
      phaseQ <= phaseD;
      armedQ <= armedD;
    end
  end

  always_comb begin
    strb      = '0;
    strb.tick = tick;
    phaseD    = phaseQ;
    armedD    = armedQ;
    if (tick) begin
      if (forceAz) begin
        phaseD    = PH_AZ;
        armedD    = 1'b1;
        strb.ldAz = 1'b1;
      end else begin
        unique case (phaseQ)
          PH_AZ: begin
            if (cntMax) begin
              phaseD     = PH_INT;
              strb.ldInt = 1'b1;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
          PH_INT: begin
            if (cntMax) begin
              phaseD      = PH_DINT;
              strb.clrCnt = 1'b1;
              strb.capPol = 1'b1;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
          PH_DINT: begin
            if (cmpFall) begin
              phaseD       = PH_IZ;
              strb.capDint = 1'b1;
            end else if (cntMax) begin
              phaseD       = PH_IZ;
              strb.capDint = 1'b1;
              strb.capOver = 1'b1;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
          PH_IZ: begin
            if (armedQ && cmpLvl) begin
              phaseD         = PH_AZ;
              strb.ldAz      = 1'b1;
              strb.pubResult = 1'b1;
            end
          end
        endcase
      end
    end
  end

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != $past(phaseQ) && !$past(forceAz)) |-> phaseQ == nextPhase($past(phaseQ))); // R1

  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != $past(phaseQ)) |-> $past(tick)); // R2

  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tick) && $past(forceAz)) |-> phaseQ == PH_AZ); // R6

  AST_ARM_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phaseQ) == PH_IZ && phaseQ == PH_AZ && !$past(forceAz)) |-> $past(armedQ)); // R8

endmodule

// File: rtl/dsadc_dpath.sv
module dsadc_dpath
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strb,
  input  logic                   loadStrobe,
  input  logic [CNT_W-LOW_W-1:0] loadValue,
  input  logic                   cmptrIn,
  output logic                   cntMax,
  output logic                   cmpLvl,
  output logic                   cmpFall,
  output logic [CNT_W-1:0]       resultCount,
  output logic                   resultOver,
  output logic                   resultPol
);

  localparam int LD_W = CNT_W - LOW_W;

  logic [1:0]       syncQ;
  logic             cmpPrevQ;
  logic [LD_W-1:0]  pendLoad, activeLoad;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] dintCnt;
  logic             dintOver, polQ;

  assign cmpLvl  = syncQ[1];
  assign cmpFall = cmpPrevQ & ~syncQ[1];
  assign cntMax  = &cntQ;

  // comparator synchronizer and tick-rate edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      cmpPrevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], cmptrIn};
      if (strb.tick) cmpPrevQ <= syncQ[1];
    end
  end

  // timing value: captured on strobe, applied when AZ counting starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLoad   <= '0;
      activeLoad <= '0;
    end else begin
      if (loadStrobe) pendLoad <= loadValue;
      if (strb.ldAz)  activeLoad <= pendLoad;
    end
  end

  // shared phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.ldAz) begin
      cntQ <= {pendLoad, {LOW_W{1'b0}}};
    end else if (strb.ldInt) begin
      cntQ <= {activeLoad, {LOW_W{1'b0}}};
    end else if (strb.clrCnt) begin
      cntQ <= '0;
    end else if (strb.incCnt) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // conversion capture and publication
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dintCnt     <= '0;
      dintOver    <= 1'b0;
      polQ        <= 1'b0;
      resultCount <= '0;
      resultOver  <= 1'b0;
      resultPol   <= 1'b0;
    end else begin
      if (strb.capPol) polQ <= syncQ[1];
      if (strb.capDint) begin
        dintCnt  <= cntQ;
        dintOver <= strb.capOver;
      end
      if (strb.pubResult) begin
        resultCount <= dintCnt;
        resultOver  <= dintOver;
        resultPol   <= polQ;
      end
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.pubResult) |-> ($stable(resultCount) && $stable(resultOver) && $stable(resultPol))); // R9

  AST_OVR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    resultOver |-> (&resultCount)); // R10

  AST_LOAD_AT_AZ: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.ldAz) |-> $stable(activeLoad)); // R12

endmodule

// File: rtl/dsadc_phase_seq.sv
module dsadc_phase_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOW_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   convEnN,
  input  logic                   loadStrobe,
  input  logic [CNT_W-LOW_W-1:0] loadValue,
  input  logic                   cmptrIn,
  output logic [1:0]             phaseCode,
  output logic                   dataValidN,
  output logic [CNT_W-1:0]       resultCount,
  output logic                   resultOver,
  output logic                   resultPol
);

  phase_e     phase;
  seqStrobe_t strb;
  logic       cntMax, cmpLvl, cmpFall;

  dsadc_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .forceAz (convEnN | loadStrobe),
    .cntMax  (cntMax),
    .cmpLvl  (cmpLvl),
    .cmpFall (cmpFall),
    .phaseQ  (phase),
    .strb    (strb)
  );

  dsadc_dpath #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .loadStrobe  (loadStrobe),
    .loadValue   (loadValue),
    .cmptrIn     (cmptrIn),
    .cntMax      (cntMax),
    .cmpLvl      (cmpLvl),
    .cmpFall     (cmpFall),
    .resultCount (resultCount),
    .resultOver  (resultOver),
    .resultPol   (resultPol)
  );

  assign phaseCode  = phase;
  assign dataValidN = (phase != PH_AZ);

endmodule

// File: tb/tb_dsadc_phase_seq.sv
module tb_dsadc_phase_seq;

  localparam int CNT_W = 12;
  localparam int LOW_W = 8;
  localparam int LD_W  = CNT_W - LOW_W;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            convEnN = 1'b0;
  logic            loadStrobe = 1'b0;
  logic [LD_W-1:0] loadValue = '0;
  logic            cmptrIn = 1'b1;
  logic [1:0]      phaseCode;
  logic            dataValidN;
  logic [CNT_W-1:0] resultCount;
  logic            resultOver, resultPol;

  always #2 clk = ~clk;

  dsadc_phase_seq #(.CNT_W(CNT_W), .LOW_W(LOW_W), .TICK_DIV(4)) dut (
    .clk(clk), .rstN(rstN), .convEnN(convEnN), .loadStrobe(loadStrobe),
    .loadValue(loadValue), .cmptrIn(cmptrIn), .phaseCode(phaseCode),
    .dataValidN(dataValidN), .resultCount(resultCount),
    .resultOver(resultOver), .resultPol(resultPol)
  );

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  // behavioural reference model, stepped on every rising edge
  int mDiv, mPh, mCnt, mArmed, mS1, mS2, mPrev, mPend, mAct;
  int mDCnt, mDOver, mPol, rCnt, rOver, rPol;
  bit mTick, mFall, mFrc, mMax;

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mPh = 0; mCnt = 0; mArmed = 0; mS1 = 0; mS2 = 0; mPrev = 0;
      mPend = 0; mAct = 0; mDCnt = 0; mDOver = 0; mPol = 0;
      rCnt = 0; rOver = 0; rPol = 0;
    end else begin
      mTick = (mDiv == 3);
      mDiv = (mDiv + 1) % 4;
      if (mTick) begin
        mFall = (mPrev == 1) && (mS2 == 0);
        mFrc  = convEnN || loadStrobe;
        mMax  = (mCnt == CMAX);
        if (mFrc) begin
          mPh = 1; mArmed = 1; mAct = mPend; mCnt = mAct << LOW_W;
        end else begin
          case (mPh)
            1: if (mMax) begin mPh = 2; mCnt = mAct << LOW_W; end else mCnt++;
            2: if (mMax) begin mPh = 3; mCnt = 0; mPol = mS2; end else mCnt++;
            3: if (mFall) begin mPh = 0; mDCnt = mCnt; mDOver = 0; end
               else if (mMax) begin mPh = 0; mDCnt = mCnt; mDOver = 1; end
               else mCnt++;
            default: if (mArmed == 1 && mS2 == 1) begin
              mPh = 1; mAct = mPend; mCnt = mAct << LOW_W;
              rCnt = mDCnt; rOver = mDOver; rPol = mPol;
            end
          endcase
        end
        mPrev = mS2;
      end
      if (loadStrobe) mPend = int'(loadValue);
      mS2 = mS1;
      mS1 = int'(cmptrIn);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R1 R2 R5 R6 phase vs model", phaseCode, mPh);
      chk("R7 dataValidN vs model", dataValidN, (mPh == 1) ? 0 : 1);
      chk("R4 R9 resultCount vs model", resultCount, rCnt);
      chk("R10 resultOver vs model", resultOver, rOver);
      chk("R11 resultPol vs model", resultPol, rPol);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  task automatic waitPhase(input int code);
    while (phaseCode != code) @(negedge clk);
  endtask

  task automatic measure(input int code, output int len);
    waitPhase(code);
    len = 0;
    while (phaseCode == code) begin len++; @(negedge clk); end
  endtask

  // raiseAt/dropAt are clock offsets into DINT, -1 for none
  task automatic runDint(input int raiseAt, input int dropAt, output int len);
    waitPhase(3);
    len = 0;
    while (phaseCode == 3) begin
      if (len == raiseAt) cmptrIn = 1'b1;
      if (len == dropAt)  cmptrIn = 1'b0;
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    int n;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 reset phase IZ", phaseCode, 0);
    chk("R8 reset dataValidN", dataValidN, 1);
    chk("R8 reset resultCount", resultCount, 0);
    repeat (40) @(negedge clk);
    chk("R8 IZ kept without forced AZ", phaseCode, 0);

    // timing value 15 -> 4096-3840 = 256 ticks = 1024 clocks
    loadValue = 4'd15;
    loadStrobe = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 R12 strobe forces AZ", phaseCode, 1);
    chk("R7 dataValidN low in forced AZ", dataValidN, 0);
    loadStrobe = 1'b0;

    measure(2, len);
    chk("R2 R3 INT length clocks", len, 1024);
    loadValue = 4'd0; // no strobe: must be ignored

    // conversion 1: positive, drop 40 clocks into DINT
    runDint(-1, 40, len);
    chk("R4 DINT length clocks", len, ((40 + 6) / 4) * 4);
    repeat (20) @(negedge clk);
    chk("R5 IZ held while comparator low", phaseCode, 0);
    chk("R9 result unchanged in IZ", resultCount, 0);
    cmptrIn = 1'b1;
    measure(1, len);
    chk("R3 R12 AZ length clocks", len, 1024);
    chk("R4 R9 count conv1", resultCount, (40 + 6) / 4 - 1);
    chk("R11 polarity conv1", resultPol, 1);
    chk("R10 no overrange conv1", resultOver, 0);

    // conversion 2: comparator low at INT end
    cmptrIn = 1'b0;
    runDint(0, 20, len);
    chk("R4 DINT length conv2", len, ((20 + 6) / 4) * 4);
    chk("R9 result held until AZ", resultCount, 10);
    cmptrIn = 1'b1;
    waitPhase(1);
    chk("R4 count conv2", resultCount, (20 + 6) / 4 - 1);
    chk("R11 polarity conv2", resultPol, 0);

    // conversion 3: comparator never falls
    runDint(-1, -1, len);
    chk("R10 DINT timeout clocks", len, 4 * (CMAX + 1));
    waitPhase(1);
    chk("R10 overrange flag", resultOver, 1);
    chk("R10 saturated count", resultCount, CMAX);

    // forcing during INT
    waitPhase(2);
    repeat (100) @(negedge clk);
    convEnN = 1'b1;
    n = 0;
    while (phaseCode != 1 && n < 10) begin n++; @(negedge clk); end
    chk("R2 force seen within one tick", (n <= 4) ? 1 : 0, 1);
    repeat (40) @(negedge clk);
    chk("R6 AZ held while enable high", phaseCode, 1);
    chk("R7 dataValidN while forced", dataValidN, 0);
    chk("R9 forced AZ keeps result", resultOver, 1);
    convEnN = 1'b0;
    measure(2, len);
    chk("R6 R3 INT after release", len, 1024);

    // new timing value 14 -> 512 ticks
    waitPhase(3);
    loadValue = 4'd14;
    loadStrobe = 1'b1;
    repeat (8) @(negedge clk);
    loadStrobe = 1'b0;
    chk("R9 strobe AZ keeps result", resultCount, CMAX);
    measure(2, len);
    chk("R12 R3 INT with new value", len, 2048);

    finishRun();
  end

endmodule